// File: doc/BRIEF.md
# Multi-Mode Digital Clock Controller

This block is the control core of a small digital clock. It runs on the system clock and advances on a single-cycle enable, `tick_i`, which arrives ten thousand times a second. Four key strobes, already debounced and one cycle long, drive it. A mode key steps through five views. In the two edit views, a select key moves a cursor over six digit positions and an increment key bumps the digit under the cursor. A commit key copies the edited time into the running clock.

The block holds four counters: the running time of day, an edit buffer, an alarm time and a hundredths-of-a-second stopwatch. It also holds a three-step brightness setting. It presents six BCD digits for whichever view is active. It raises a tone output, a square wave, while the running time agrees with the alarm down to the tens of seconds. Segment decoding, multiplexed scanning, dimming and debouncing all sit outside the block.

Top module: `dclk_ctrl`

## Requirements
- R1: Reset leaves the block in the time view. The running time and edit buffer read 00:00:00, the alarm reads 12:00:00, and the stopwatch reads 00:00.00 and is stopped. Brightness code is 0, both edit cursors sit on position 0 and `tone_o` is 1.
- R2: Each `key_mode_i` pulse steps the view in this order: time view → time edit → stopwatch → alarm edit → brightness → time view.
- R3: In the time-edit and alarm-edit views, `key_sel_i` moves that view's cursor to the next position, from 5 back to 0. Each view has its own cursor. Position p is shown on `digits_o[4p+3:4p]`: 0 seconds units, 1 seconds tens, 2 minutes units, 3 minutes tens, 4 hours units, 5 hours tens.
- R4: In those views, `key_inc_i` adds one to the digit under the cursor. Positions 0, 2 and 4 return to 0 after 9, positions 1 and 3 after 5, and position 5 after 2. The time-edit view shows the edit buffer and the alarm-edit view shows the alarm.
- R5: `key_commit_i`, in any view, loads the edit buffer into the running time on the next edge. An hour value above 23 is loaded as 23, and the count toward the next second restarts from zero.
- R6: The running time gains one second every `CENTI_PER_SEC` hundredth periods, each `TICKS_PER_CENTI` ticks long. Seconds and minutes roll over after 59 with a carry, and 23:59:59 rolls over to 00:00:00. The time view shows hh mm ss.
- R7: In the stopwatch view, `key_sel_i` toggles run/pause and `key_inc_i` clears the count to zero. A clear does not change the run state. While running, the count gains one hundredth every `TICKS_PER_CENTI` ticks. The view shows minutes, seconds, hundredths in positions 5..0.
- R8: The stopwatch rolls over from (`SW_MINUTES`−1):59.99 to 00:00.00. It keeps its count and keeps running while other views are shown.
- R9: When the running hours, minutes and seconds-tens all equal the alarm's, `tone_o` follows a square wave that starts low after reset and flips every `TONE_HALF_TICKS` ticks. At all other times `tone_o` is 1.
- R10: In the brightness view, `key_sel_i` steps `bright_o` through 0 → 1 → 2 → 0, and all six digits read 8.
- R11: A key pulse has no effect in a view where that key has no function. Select and increment do nothing in the time view. Increment does nothing in the brightness view. Select and increment never touch a view other than the current one.
- R12: Every digit on `digits_o` is a BCD value from 0 to 9.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick_i | input | 1 | Timebase enable, one cycle per 0.1 ms |
| key_mode_i | input | 1 | View-step strobe |
| key_sel_i | input | 1 | Cursor / run-pause / brightness strobe |
| key_inc_i | input | 1 | Digit increment / stopwatch clear strobe |
| key_commit_i | input | 1 | Load edit buffer into running time |
| digits_o | output | 24 | Six BCD digits; position p in bits 4p+3:4p |
| bright_o | output | 2 | Brightness level code 0..2 |
| tone_o | output | 1 | Alarm tone, idle high |

## Verification
Every register in this block reaches `digits_o`, `bright_o` or `tone_o` within one cycle once the matching view is selected. A bad view index, a cursor on the wrong digit or a missed carry therefore shows on the digits at the next sampled cycle. A prescaler that is off by one count drifts the displayed seconds, stopwatch hundredths or tone edges within a single period. A bad alarm comparison shows as a tone that toggles when it should rest, or rests when it should toggle. The bench compares all three outputs every cycle against an independent model, so most faults surface within a few cycles of the stimulus that exposes them.

// File: rtl/dclk_pkg.sv
package dclk_pkg;

    // six BCD digits, index 0 = seconds (or hundredths) units
    typedef logic [5:0][3:0] bcd6_t;

    typedef enum logic [2:0] {
        V_SHOW   = 3'd0,
        V_TSET   = 3'd1,
        V_WATCH  = 3'd2,
        V_ASET   = 3'd3,
        V_BRIGHT = 3'd4
    } view_e;

    localparam bcd6_t ALL_EIGHTS = {6{4'd8}};
    localparam bcd6_t NOON       = {4'd1, 4'd2, 4'd0, 4'd0, 4'd0, 4'd0};

    // highest legal value of a time-of-day digit position
    function automatic logic [3:0] digit_limit(input logic [2:0] pos);
        case (pos)
            3'd1, 3'd3: digit_limit = 4'd5;
            3'd5:       digit_limit = 4'd2;
            default:    digit_limit = 4'd9;
        endcase
    endfunction

endpackage

// File: rtl/dclk_timebase.sv
module dclk_timebase #(
    parameter int TICKS_PER_CENTI = 100,
    parameter int CENTI_PER_SEC   = 100,
    parameter int TONE_HALF_TICKS = 50
) (
    input  logic clk,
    input  logic rst_n,
    input  logic tick_i,
    input  logic restart_i,
    output logic centi_en_o,
    output logic sec_en_o,
    output logic tone_ph_o
);
    localparam int TW = (TICKS_PER_CENTI > 1) ? $clog2(TICKS_PER_CENTI) : 1;
    localparam int CW = (CENTI_PER_SEC   > 1) ? $clog2(CENTI_PER_SEC)   : 1;
    localparam int HW = (TONE_HALF_TICKS > 1) ? $clog2(TONE_HALF_TICKS) : 1;
    localparam logic [TW-1:0] T_LAST = TW'(TICKS_PER_CENTI - 1);
    localparam logic [CW-1:0] C_LAST = CW'(CENTI_PER_SEC - 1);
    localparam logic [HW-1:0] H_LAST = HW'(TONE_HALF_TICKS - 1);

    typedef struct packed {
        logic [TW-1:0] tcnt;
        logic [CW-1:0] ccnt;
        logic [HW-1:0] hcnt;
        logic          ph;
    } tb_t;

    tb_t  tb_d, tb_q;
    logic centi;

    always_comb begin
        tb_d  = tb_q;
        centi = tick_i && (tb_q.tcnt == T_LAST);
        if (tick_i)
            tb_d.tcnt = centi ? '0 : tb_q.tcnt + TW'(1);
        if (restart_i)
            tb_d.ccnt = '0;
        else if (centi)
            tb_d.ccnt = (tb_q.ccnt == C_LAST) ? '0 : tb_q.ccnt + CW'(1);
        if (tick_i) begin
            if (tb_q.hcnt == H_LAST) begin
                tb_d.hcnt = '0;
                tb_d.ph   = ~tb_q.ph;
            end else begin
                tb_d.hcnt = tb_q.hcnt + HW'(1);
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) tb_q <= '0;
        else        tb_q <= tb_d;
    end

    assign centi_en_o = centi;
    assign sec_en_o   = centi && (tb_q.ccnt == C_LAST) && !restart_i;
    assign tone_ph_o  = tb_q.ph;

endmodule

// File: rtl/dclk_digit_editor.sv
module dclk_digit_editor
    import dclk_pkg::*;
#(
    parameter bcd6_t INIT = '0
) (
    input  logic  clk,
    input  logic  rst_n,
    input  logic  en_i,
    input  logic  sel_i,
    input  logic  inc_i,
    output bcd6_t value_o
);
    typedef struct packed {
        logic [2:0] pos;
        bcd6_t      val;
    } ed_t;

    ed_t ed_d, ed_q;

    always_comb begin
        ed_d = ed_q;
        if (en_i && inc_i) begin
            if (ed_q.val[ed_q.pos] == digit_limit(ed_q.pos))
                ed_d.val[ed_q.pos] = 4'd0;
            else
                ed_d.val[ed_q.pos] = ed_q.val[ed_q.pos] + 4'd1;
        end
        if (en_i && sel_i)
            ed_d.pos = (ed_q.pos == 3'd5) ? 3'd0 : ed_q.pos + 3'd1;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ed_q.pos <= 3'd0;
            ed_q.val <= INIT;
        end else begin
            ed_q <= ed_d;
        end
    end

    assign value_o = ed_q.val;

endmodule

// File: rtl/dclk_runtime.sv
module dclk_runtime
    import dclk_pkg::*;
(
    input  logic  clk,
    input  logic  rst_n,
    input  logic  sec_en_i,
    input  logic  load_i,
    input  bcd6_t load_val_i,
    output bcd6_t time_o
);
    bcd6_t tm_d, tm_q;
    logic  carry;

    always_comb begin
        tm_d  = tm_q;
        carry = 1'b0;
        if (load_i) begin
            tm_d = load_val_i;
            if (load_val_i[5] > 4'd2 || (load_val_i[5] == 4'd2 && load_val_i[4] > 4'd3)) begin
                tm_d[5] = 4'd2;
                tm_d[4] = 4'd3;
            end
        end else if (sec_en_i) begin
            carry = 1'b1;
            for (int p = 0; p < 4; p++) begin
                if (carry) begin
                    if (tm_q[p] == digit_limit(3'(p))) begin
                        tm_d[p] = 4'd0;
                    end else begin
                        tm_d[p] = tm_q[p] + 4'd1;
                        carry   = 1'b0;
                    end
                end
            end
            if (carry) begin
                if (tm_q[5] == 4'd2 && tm_q[4] == 4'd3) begin
                    tm_d[5] = 4'd0;
                    tm_d[4] = 4'd0;
                end else if (tm_q[4] == 4'd9) begin
                    tm_d[4] = 4'd0;
                    tm_d[5] = tm_q[5] + 4'd1;
                end else begin
                    tm_d[4] = tm_q[4] + 4'd1;
                end
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) tm_q <= '0;
        else        tm_q <= tm_d;
    end

    assign time_o = tm_q;

endmodule

// File: rtl/dclk_stopwatch.sv
module dclk_stopwatch
    import dclk_pkg::*;
#(
    parameter int SW_MINUTES = 60
) (
    input  logic  clk,
    input  logic  rst_n,
    input  logic  centi_en_i,
    input  logic  toggle_i,
    input  logic  clear_i,
    output bcd6_t count_o
);
    localparam logic [3:0] MT = 4'((SW_MINUTES - 1) / 10);
    localparam logic [3:0] MU = 4'((SW_MINUTES - 1) % 10);
    // per-position limits: hundredths, seconds, minutes
    localparam bcd6_t LIM = {4'd9, 4'd9, 4'd5, 4'd9, 4'd9, 4'd9};
    localparam bcd6_t TOP = {MT, MU, 4'd5, 4'd9, 4'd9, 4'd9};

    typedef struct packed {
        logic  run;
        bcd6_t cnt;
    } sw_t;

    sw_t  sw_d, sw_q;
    logic carry;

    always_comb begin
        sw_d  = sw_q;
        carry = 1'b0;
        if (toggle_i)
            sw_d.run = ~sw_q.run;
        if (clear_i) begin
            sw_d.cnt = '0;
        end else if (sw_q.run && centi_en_i) begin
            if (sw_q.cnt == TOP) begin
                sw_d.cnt = '0;
            end else begin
                carry = 1'b1;
                for (int p = 0; p < 6; p++) begin
                    if (carry) begin
                        if (sw_q.cnt[p] == LIM[p]) begin
                            sw_d.cnt[p] = 4'd0;
                        end else begin
                            sw_d.cnt[p] = sw_q.cnt[p] + 4'd1;
                            carry       = 1'b0;
                        end
                    end
                end
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) sw_q <= '0;
        else        sw_q <= sw_d;
    end

    assign count_o = sw_q.cnt;

endmodule

// File: rtl/dclk_ctrl.sv
module dclk_ctrl
    import dclk_pkg::*;
#(
    parameter int TICKS_PER_CENTI = 100,
    parameter int CENTI_PER_SEC   = 100,
    parameter int TONE_HALF_TICKS = 50,
    parameter int SW_MINUTES      = 60
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        tick_i,
    input  logic        key_mode_i,
    input  logic        key_sel_i,
    input  logic        key_inc_i,
    input  logic        key_commit_i,
    output logic [23:0] digits_o,
    output logic [1:0]  bright_o,
    output logic        tone_o
);
    typedef struct packed {
        view_e      view;
        logic [1:0] bright;
    } top_t;

    top_t  st_d, st_q;
    view_e cur_view;
    logic  centi_en, sec_en, tone_ph, alarm_hit;
    bcd6_t run_time, edit_time, alarm_time, sw_time;

    assign cur_view = st_q.view;

    dclk_timebase #(
        .TICKS_PER_CENTI (TICKS_PER_CENTI),
        .CENTI_PER_SEC   (CENTI_PER_SEC),
        .TONE_HALF_TICKS (TONE_HALF_TICKS)
    ) u_tb (
        .clk        (clk),
        .rst_n      (rst_n),
        .tick_i     (tick_i),
        .restart_i  (key_commit_i),
        .centi_en_o (centi_en),
        .sec_en_o   (sec_en),
        .tone_ph_o  (tone_ph)
    );

    dclk_digit_editor #(.INIT('0)) u_edit (
        .clk     (clk),
        .rst_n   (rst_n),
        .en_i    (cur_view == V_TSET),
        .sel_i   (key_sel_i),
        .inc_i   (key_inc_i),
        .value_o (edit_time)
    );

    dclk_digit_editor #(.INIT(NOON)) u_alarm (
        .clk     (clk),
        .rst_n   (rst_n),
        .en_i    (cur_view == V_ASET),
        .sel_i   (key_sel_i),
        .inc_i   (key_inc_i),
        .value_o (alarm_time)
    );

    dclk_runtime u_run (
        .clk        (clk),
        .rst_n      (rst_n),
        .sec_en_i   (sec_en),
        .load_i     (key_commit_i),
        .load_val_i (edit_time),
        .time_o     (run_time)
    );

    dclk_stopwatch #(.SW_MINUTES(SW_MINUTES)) u_sw (
        .clk        (clk),
        .rst_n      (rst_n),
        .centi_en_i (centi_en),
        .toggle_i   (key_sel_i && cur_view == V_WATCH),
        .clear_i    (key_inc_i && cur_view == V_WATCH),
        .count_o    (sw_time)
    );

    always_comb begin
        st_d = st_q;
        if (key_mode_i) begin
            case (st_q.view)
                V_SHOW:  st_d.view = V_TSET;
                V_TSET:  st_d.view = V_WATCH;
                V_WATCH: st_d.view = V_ASET;
                V_ASET:  st_d.view = V_BRIGHT;
                default: st_d.view = V_SHOW;
            endcase
        end
        if (key_sel_i && st_q.view == V_BRIGHT)
            st_d.bright = (st_q.bright == 2'd2) ? 2'd0 : st_q.bright + 2'd1;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q.view   <= V_SHOW;
            st_q.bright <= 2'd0;
        end else begin
            st_q <= st_d;
        end
    end

    always_comb begin
        case (cur_view)
            V_TSET:   digits_o = edit_time;
            V_WATCH:  digits_o = sw_time;
            V_ASET:   digits_o = alarm_time;
            V_BRIGHT: digits_o = ALL_EIGHTS;
            default:  digits_o = run_time;
        endcase
    end

    // positions 1..5: seconds tens, minutes, hours
    assign alarm_hit = (run_time[5:1] == alarm_time[5:1]);
    assign tone_o    = alarm_hit ? tone_ph : 1'b1;
    assign bright_o  = st_q.bright;

endmodule

// File: rtl/dclk_chk.sv
module dclk_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        key_mode_i,
    input logic        key_sel_i,
    input logic        key_inc_i,
    input logic [2:0]  view_q,
    input logic [1:0]  bright_o,
    input logic [23:0] digits_o,
    input logic [23:0] run_time,
    input logic [23:0] sw_time
);
    p_view_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
        key_mode_i |=> view_q == (($past(view_q) == 3'd4) ? 3'd0 : $past(view_q) + 3'd1));

    p_view_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !key_mode_i |=> $stable(view_q));

    p_bright_range_r10: assert property (@(posedge clk) disable iff (!rst_n)
        bright_o != 2'd3);

    p_bright_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
        !(view_q == 3'd4 && key_sel_i) |=> $stable(bright_o));

    p_time_legal_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (run_time[23:20] < 4'd2 || (run_time[23:20] == 4'd2 && run_time[19:16] <= 4'd3))
        && run_time[15:12] <= 4'd5 && run_time[7:4] <= 4'd5);

    p_sw_clear_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (view_q == 3'd2 && key_inc_i) |=> sw_time == 24'd0);

    p_sw_legal_r8: assert property (@(posedge clk) disable iff (!rst_n)
        sw_time[15:12] <= 4'd5);

    p_digits_bcd_r12: assert property (@(posedge clk) disable iff (!rst_n)
        digits_o[3:0] <= 4'd9 && digits_o[7:4] <= 4'd9 && digits_o[11:8] <= 4'd9 &&
        digits_o[15:12] <= 4'd9 && digits_o[19:16] <= 4'd9 && digits_o[23:20] <= 4'd9);

endmodule

bind dclk_ctrl dclk_chk u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .key_mode_i (key_mode_i),
    .key_sel_i  (key_sel_i),
    .key_inc_i  (key_inc_i),
    .view_q     (cur_view),
    .bright_o   (bright_o),
    .digits_o   (digits_o),
    .run_time   (run_time),
    .sw_time    (sw_time)
);

// File: tb/tb_dclk_ctrl.sv
module tb_dclk_ctrl;
    localparam int TPC = 2;
    localparam int CPS = 3;
    localparam int TH  = 3;
    localparam int SWM = 2;
    localparam int SW_WRAP = SWM * 6000;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic tick = 1'b0, km = 1'b0, ks = 1'b0, ki = 1'b0, kc = 1'b0;
    logic [23:0] digits_o;
    logic [1:0]  bright_o;
    logic        tone_o;

    always #2 clk = ~clk;

    dclk_ctrl #(
        .TICKS_PER_CENTI (TPC),
        .CENTI_PER_SEC   (CPS),
        .TONE_HALF_TICKS (TH),
        .SW_MINUTES      (SWM)
    ) dut (
        .clk          (clk),
        .rst_n        (rst_n),
        .tick_i       (tick),
        .key_mode_i   (km),
        .key_sel_i    (ks),
        .key_inc_i    (ki),
        .key_commit_i (kc),
        .digits_o     (digits_o),
        .bright_o     (bright_o),
        .tone_o       (tone_o)
    );

    int errs = 0, checks = 0;
    string dtag = "";
    bit tick_on = 1'b0;
    bit rnd_tick = 1'b0;

    // reference state
    int m_view = 0, m_run = 0, m_epos = 0, m_apos = 0, m_sw = 0, m_swrun = 0;
    int m_bright = 0, m_tc = 0, m_cc = 0, m_hc = 0, m_ph = 0;
    int m_edit[6] = '{0, 0, 0, 0, 0, 0};
    int m_alarm[6] = '{0, 0, 0, 0, 2, 1};

    function automatic int lim(int p);
        return (p == 5) ? 2 : ((p == 1 || p == 3) ? 5 : 9);
    endfunction

    function automatic logic [23:0] pack2(int hi, int mid, int lo);
        return {4'(hi / 10), 4'(hi % 10), 4'(mid / 10), 4'(mid % 10), 4'(lo / 10), 4'(lo % 10)};
    endfunction

    function automatic logic [23:0] pack_arr(int a[6]);
        return {4'(a[5]), 4'(a[4]), 4'(a[3]), 4'(a[2]), 4'(a[1]), 4'(a[0])};
    endfunction

    function automatic logic [23:0] exp_digits();
        case (m_view)
            0: return pack2(m_run / 3600, (m_run / 60) % 60, m_run % 60);
            1: return pack_arr(m_edit);
            2: return pack2(m_sw / 6000, (m_sw / 100) % 60, m_sw % 100);
            3: return pack_arr(m_alarm);
            default: return 24'h888888;
        endcase
    endfunction

    function automatic logic exp_tone();
        bit hit;
        hit = (m_run / 3600 == m_alarm[5] * 10 + m_alarm[4]) &&
              ((m_run / 60) % 60 == m_alarm[3] * 10 + m_alarm[2]) &&
              ((m_run % 60) / 10 == m_alarm[1]);
        return hit ? 1'(m_ph) : 1'b1;
    endfunction

    function automatic string view_tag();
        case (m_view)
            0: return "R6";
            1: return "R4";
            2: return "R7";
            3: return "R4";
            default: return "R10";
        endcase
    endfunction

    task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errs++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic model_step(bit t, bit a_mode, bit a_sel, bit a_inc, bit a_com);
        bit centi, sec;
        int h;
        centi = t && (m_tc == TPC - 1);
        sec = centi && (m_cc == CPS - 1) && !a_com;
        if (t) m_tc = centi ? 0 : m_tc + 1;
        if (a_com) m_cc = 0;
        else if (centi) m_cc = (m_cc == CPS - 1) ? 0 : m_cc + 1;
        if (t) begin
            if (m_hc == TH - 1) begin m_hc = 0; m_ph = 1 - m_ph; end
            else m_hc++;
        end
        if (a_com) begin
            h = m_edit[5] * 10 + m_edit[4];
            if (h > 23) h = 23;
            m_run = h * 3600 + (m_edit[3] * 10 + m_edit[2]) * 60 + m_edit[1] * 10 + m_edit[0];
        end else if (sec) begin
            m_run = (m_run + 1) % 86400;
        end
        if (m_view == 1) begin
            if (a_inc) m_edit[m_epos] = (m_edit[m_epos] == lim(m_epos)) ? 0 : m_edit[m_epos] + 1;
            if (a_sel) m_epos = (m_epos + 1) % 6;
        end
        if (m_view == 3) begin
            if (a_inc) m_alarm[m_apos] = (m_alarm[m_apos] == lim(m_apos)) ? 0 : m_alarm[m_apos] + 1;
            if (a_sel) m_apos = (m_apos + 1) % 6;
        end
        if (m_view == 2 && a_inc) m_sw = 0;
        else if (m_swrun != 0 && centi) m_sw = (m_sw + 1) % SW_WRAP;
        if (m_view == 2 && a_sel) m_swrun = 1 - m_swrun;
        if (m_view == 4 && a_sel) m_bright = (m_bright + 1) % 3;
        if (a_mode) m_view = (m_view + 1) % 5;
    endtask

    task automatic check_all();
        chk((dtag != "") ? dtag : view_tag(), 32'(digits_o), 32'(exp_digits()));
        chk("R10", 32'(bright_o), 32'(m_bright));
        chk("R9", 32'(tone_o), 32'(exp_tone()));
    endtask

    // one clock: drive at the falling edge, compare at the next falling edge
    task automatic cyc(bit a_mode, bit a_sel, bit a_inc, bit a_com);
        bit t;
        t = rnd_tick ? ($urandom % 4 != 0) : tick_on;
        tick = t; km = a_mode; ks = a_sel; ki = a_inc; kc = a_com;
        model_step(t, a_mode, a_sel, a_inc, a_com);
        @(negedge clk);
        tick = 1'b0; km = 1'b0; ks = 1'b0; ki = 1'b0; kc = 1'b0;
        check_all();
    endtask

    task automatic idle(int n);
        for (int i = 0; i < n; i++) cyc(0, 0, 0, 0);
    endtask

    task automatic to_view(int v);
        while (m_view != v) cyc(1, 0, 0, 0);
    endtask

    // set all six digits of the current edit view to the given values
    task automatic set_digits(int t5, int t4, int t3, int t2, int t1, int t0);
        int tgt[6];
        tgt = '{t0, t1, t2, t3, t4, t5};
        for (int p = 0; p < 6; p++) begin
            while (((m_view == 1) ? m_epos : m_apos) != p) cyc(0, 1, 0, 0);
            while (((m_view == 1) ? m_edit[p] : m_alarm[p]) != tgt[p]) cyc(0, 0, 1, 0);
        end
    endtask

    initial begin
        #(4 * 190000);
        errs++;
        checks++;
        $display("FAIL watchdog: actual timeout expected finish");
        $display("  Result: errors=%0d of %0d checks", errs, checks);
        $finish;
    end

    initial begin
        logic [23:0] snap;
        bit seen_lo, seen_hi, found;
        void'($urandom(32'd4242));
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1: reset state
        chk("R1", 32'(digits_o), 32'h000000);
        chk("R1", 32'(bright_o), 32'h0);
        chk("R1", 32'(tone_o), 32'h1);

        // R2: view order
        dtag = "R2";
        to_view(4);
        chk("R2", 32'(digits_o), 32'h888888);
        cyc(1, 0, 0, 0);
        chk("R2", 32'(digits_o), 32'h000000);

        // R11: select/increment in time view do nothing
        dtag = "R11";
        cyc(0, 1, 0, 0); cyc(0, 0, 1, 0);
        chk("R11", 32'(digits_o), 32'h000000);
        cyc(1, 0, 0, 0);
        chk("R11", 32'(digits_o), 32'h000000);

        // R4: per-digit wrap limits
        dtag = "R4";
        for (int i = 0; i < 9; i++) cyc(0, 0, 1, 0);
        chk("R4", 32'(digits_o), 32'h000009);
        cyc(0, 0, 1, 0);
        chk("R4", 32'(digits_o), 32'h000000);
        cyc(0, 1, 0, 0);
        for (int i = 0; i < 5; i++) cyc(0, 0, 1, 0);
        chk("R4", 32'(digits_o), 32'h000050);
        cyc(0, 0, 1, 0);
        chk("R4", 32'(digits_o), 32'h000000);
        for (int i = 0; i < 4; i++) cyc(0, 1, 0, 0);
        cyc(0, 0, 1, 0); cyc(0, 0, 1, 0);
        chk("R4", 32'(digits_o), 32'h200000);
        cyc(0, 0, 1, 0);
        chk("R4", 32'(digits_o), 32'h000000);
        // R3: cursor wraps from position 5 to 0
        dtag = "R3";
        cyc(0, 1, 0, 0); cyc(0, 0, 1, 0);
        chk("R3", 32'(digits_o), 32'h000001);

        // R5: commit loads the running time
        dtag = "R5";
        set_digits(2, 3, 5, 9, 5, 7);
        cyc(0, 0, 0, 1);
        to_view(0);
        chk("R5", 32'(digits_o), 32'h235957);

        // R6: midnight rollover
        dtag = "R6";
        tick_on = 1'b1;
        found = 1'b0;
        for (int i = 0; i < 300 && !found; i++) begin
            cyc(0, 0, 0, 0);
            if (digits_o == 24'h000000) found = 1'b1;
        end
        chk("R6", 32'(found), 32'h1);
        tick_on = 1'b0;

        // R5: hour clamp
        dtag = "R5";
        to_view(1);
        set_digits(2, 9, 0, 0, 0, 0);
        cyc(0, 0, 0, 1);
        to_view(0);
        chk("R5", 32'(digits_o), 32'h230000);

        // R9: alarm match produces a square wave
        dtag = "R9";
        to_view(3);
        set_digits(2, 3, 0, 0, 0, 0);
        to_view(0);
        tick_on = 1'b1;
        seen_lo = 1'b0; seen_hi = 1'b0;
        for (int i = 0; i < 20; i++) begin
            cyc(0, 0, 0, 0);
            if (tone_o == 1'b0) seen_lo = 1'b1; else seen_hi = 1'b1;
        end
        chk("R9", 32'({seen_lo, seen_hi}), 32'h3);

        // R7: run, pause, clear
        dtag = "R7";
        to_view(2);
        cyc(0, 1, 0, 0);
        idle(30);
        cyc(0, 1, 0, 0);
        snap = digits_o;
        idle(10);
        chk("R7", 32'(digits_o), 32'(snap));
        chk("R7", 32'(snap != 24'h0), 32'h1);
        cyc(0, 0, 1, 0);
        chk("R7", 32'(digits_o), 32'h000000);

        // R8: rollover at the top and persistence across views
        dtag = "R8";
        cyc(0, 1, 0, 0);
        found = 1'b0;
        snap = 24'h0;
        for (int i = 0; i < 2 * SW_WRAP * TPC && !found; i++) begin
            snap = digits_o;
            cyc(0, 0, 0, 0);
            if (snap == 24'h015999 && digits_o == 24'h000000) found = 1'b1;
        end
        chk("R8", 32'(found), 32'h1);
        to_view(0);
        idle(50);
        to_view(2);
        idle(5);

        // R10: brightness steps; R11: increment ignored there
        dtag = "R10";
        to_view(4);
        cyc(0, 1, 0, 0); chk("R10", 32'(bright_o), 32'h1);
        cyc(0, 1, 0, 0); chk("R10", 32'(bright_o), 32'h2);
        dtag = "R11";
        cyc(0, 0, 1, 0); chk("R11", 32'(bright_o), 32'h2);
        dtag = "R10";
        cyc(0, 1, 0, 0); chk("R10", 32'(bright_o), 32'h0);

        // random mix; R12 digits stay BCD throughout
        dtag = "";
        rnd_tick = 1'b1;
        for (int i = 0; i < 20000; i++) begin
            cyc($urandom % 40 == 0, $urandom % 6 == 0, $urandom % 5 == 0, $urandom % 150 == 0);
            chk("R12", 32'(digits_o[3:0] <= 9 && digits_o[7:4] <= 9 && digits_o[11:8] <= 9 &&
                           digits_o[15:12] <= 9 && digits_o[19:16] <= 9 && digits_o[23:20] <= 9), 32'h1);
        end

        $display("  Result: errors=%0d of %0d checks", errs, checks);
        $finish;
    end

endmodule